// File: doc/BRIEF.md
# Iterated Modular Squaring Engine

The engine evaluates w = 2^(2^t) mod n. It starts from the value 2 and squares it modulo n, t times in sequence. The odd modulus n and its word width W are fixed when the block is built. The reduction constant -n^-1 mod 2^W and the entry factor 2^(2W) mod n are derived from them at elaboration. The squaring count t arrives on an input port together with a start request. A one-cycle done pulse marks the moment the answer is ready.

Every step runs through a single-cycle Montgomery multiplier, so reduction costs only a fixed right shift and one conditional subtraction. The operand enters the Montgomery domain once before the squaring chain and leaves it once afterwards. While the chain runs, one register holds the multiplier output and feeds it straight back to both multiplier inputs. One answer therefore costs t + 2 clock cycles in total.

Top module: `sqchain_engine`

## Requirements
- R1: When a job finishes, `result` equals 2^(2^t) mod n, where t is the `t_count` value sampled with the accepted start.
- R2: For n = 253, the counts t = 1 through 10 give 4, 16, 3, 9, 81, 236, 36, 31, 202 and 71 in that order.
- R3: With t = 0 the result is 2 mod n, and only the two domain conversions take place.
- R4: A start is accepted on a rising clock edge while `busy` is low. `done` is then high during the cycle that follows the (t+2)-th rising edge after the accepting edge.
- R5: `done` stays high for exactly one cycle per accepted job.
- R6: `result` changes only in the cycle where `done` is high. It keeps its value until the next job completes.
- R7: While `busy` is high, `start` and changes on `t_count` have no effect on the running job's result or timing.
- R8: `busy` is high from the cycle after the accepting edge until `done` rises. `busy` and `done` are never high together.
- R9: Every value held in the feedback register and on `result` is strictly below n.
- R10: While `rst` is high (synchronous, active high), and until the first job completes after it, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, taken only while idle |
| t_count | input | CW | Number of squarings for the requested job |
| busy | output | 1 | High while a job is in progress |
| done | output | 1 | One-cycle pulse when `result` has been updated |
| result | output | W | 2^(2^t) mod n of the last completed job |

## Verification
A corrupted feedback value cannot stay hidden. Squaring spreads any error over the whole residue, so the next `done` pulse carries a value that differs from the square-and-mod reference. If the error pushes a value to n or above, a checker fires on the very next cycle. A miscounting iteration counter or a wrong phase transition moves the `done` pulse away from cycle t+2, and the exact latency check catches that. A missing or doubled domain conversion leaves a residue scaled by a power of 2^W, so even t = 0 already shows the wrong value.

// File: rtl/sqchain_pkg.sv
package sqchain_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ENTER = 2'd1,
        PH_LOOP  = 2'd2,
        PH_LEAVE = 2'd3
    } phase_e;

    // Negated inverse of an odd value modulo 2^64 (Newton iteration).
    function automatic logic [63:0] calc_neg_inv(input logic [63:0] n);
        logic [63:0] x;
        x = n;
        for (int i = 0; i < 5; i++) begin
            x = x * (64'd2 - n * x);
        end
        return ~x + 64'd1;
    endfunction

    // 2^(2w) mod n by repeated doubling; valid for w <= 32.
    function automatic logic [63:0] calc_r2(input logic [63:0] n, input int w);
        logic [63:0] r;
        r = 64'd1 % n;
        for (int i = 0; i < 64; i++) begin
            if (i < 2 * w) begin
                r = r << 1;
                if (r >= n) r = r - n;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sqchain_montmul.sv
module sqchain_montmul #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MOD  = W'(65521),
    parameter logic [W-1:0] NINV = W'(1)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  m;
    logic [PW:0]   sum;
    logic [W:0]    u;

    always_comb begin
        prod = PW'(a) * PW'(b);
        m    = prod[W-1:0] * NINV;
        sum  = (PW+1)'(prod) + (PW+1)'(PW'(m) * PW'(MOD));
        u    = (W+1)'(sum >> W);
        if (u >= (W+1)'(MOD)) begin
            y = W'(u - (W+1)'(MOD));
        end else begin
            y = u[W-1:0];
        end
    end
endmodule

// File: rtl/sqchain_ctrl.sv
module sqchain_ctrl
    import sqchain_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] t_count,
    output phase_e        phase,
    output logic          busy,
    output logic          done
);
    phase_e        st_q;
    logic [CW-1:0] rem_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                PH_IDLE: begin
                    if (start) begin
                        rem_q <= t_count;
                        st_q  <= PH_ENTER;
                    end
                end
                PH_ENTER: begin
                    st_q <= (rem_q == '0) ? PH_LEAVE : PH_LOOP;
                end
                PH_LOOP: begin
                    rem_q <= rem_q - CW'(1);
                    if (rem_q == CW'(1)) st_q <= PH_LEAVE;
                end
                PH_LEAVE: begin
                    st_q   <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = st_q;
    assign busy  = (st_q != PH_IDLE);
    assign done  = done_q;
endmodule

// File: rtl/sqchain_engine.sv
module sqchain_engine
    import sqchain_pkg::*;
#(
    parameter int           W   = 16,
    parameter logic [W-1:0] MOD = W'(65521),
    parameter int           CW  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] t_count,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result
);
    localparam logic [W-1:0] NINV = W'(calc_neg_inv(64'(MOD)));
    localparam logic [W-1:0] R2   = W'(calc_r2(64'(MOD), W));
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TWO  = W'(64'd2 % 64'(MOD));

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    phase_e       phase;
    opnd_t        opnd;
    logic [W-1:0] mm_y;
    logic [W-1:0] fb_q;
    logic [W-1:0] res_q;

    sqchain_ctrl #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .t_count (t_count),
        .phase   (phase),
        .busy    (busy),
        .done    (done)
    );

    always_comb begin
        case (phase)
            PH_ENTER: opnd = '{a: TWO,  b: R2};
            PH_LOOP:  opnd = '{a: fb_q, b: fb_q};
            default:  opnd = '{a: fb_q, b: ONE};
        endcase
    end

    sqchain_montmul #(.W(W), .MOD(MOD), .NINV(NINV)) u_mm (
        .a (opnd.a),
        .b (opnd.b),
        .y (mm_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= '0;
            res_q <= '0;
        end else begin
            case (phase)
                PH_ENTER, PH_LOOP: fb_q  <= mm_y;
                PH_LEAVE:          res_q <= mm_y;
                default:           ;
            endcase
        end
    end

    assign result = res_q;
endmodule

// File: rtl/sqchain_checker.sv
module sqchain_checker #(
    parameter int           W   = 16,
    parameter logic [W-1:0] MOD = W'(65521)
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] fb
);
    AST_FB_BELOW_MOD: assert property (@(posedge clk) disable iff (rst) fb < MOD); // R9
    AST_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (rst) result < MOD); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result)); // R6
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R8
    AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R8
endmodule

bind sqchain_engine sqchain_checker #(.W(W), .MOD(MOD)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .fb     (fb_q)
);

// File: tb/sqchain_engine_test.sv
module sqchain_engine_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] t_count;

    logic        busy_a, done_a, busy_b, done_b, busy_c, done_c, busy_d, done_d;
    logic [7:0]  res_a;
    logic [15:0] res_b;
    logic [31:0] res_c;
    logic [11:0] res_d;

    localparam longint unsigned NA = 253;
    localparam longint unsigned NB = 9;
    localparam longint unsigned NC = 64'hFFFF_FFFB;
    localparam longint unsigned ND = 3001;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sqchain_engine #(.W(8),  .MOD(8'd253),         .CW(16)) uut (
        .clk(clk), .rst(rst), .start(start), .t_count(t_count),
        .busy(busy_a), .done(done_a), .result(res_a));
    sqchain_engine #(.W(16), .MOD(16'd9),          .CW(16)) uut_b (
        .clk(clk), .rst(rst), .start(start), .t_count(t_count),
        .busy(busy_b), .done(done_b), .result(res_b));
    sqchain_engine #(.W(32), .MOD(32'hFFFF_FFFB),  .CW(16)) uut_c (
        .clk(clk), .rst(rst), .start(start), .t_count(t_count),
        .busy(busy_c), .done(done_c), .result(res_c));
    sqchain_engine #(.W(12), .MOD(12'd3001),       .CW(16)) uut_d (
        .clk(clk), .rst(rst), .start(start), .t_count(t_count),
        .busy(busy_d), .done(done_d), .result(res_d));

    task automatic check(input string req, input string what,
                         input longint unsigned got, input longint unsigned exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint unsigned ref_sq(input longint unsigned n, input int t);
        longint unsigned x;
        x = 64'd2 % n;
        for (int i = 0; i < t; i++) x = (x * x) % n;
        return x;
    endfunction

    // Runs one job; noise_at in 1..t injects a start and a new count while busy.
    task automatic run_job(input int t, input int noise_at, input string req);
        int k;
        bit seen;
        longint unsigned ha, hb, hc, hd;
        @(posedge clk); #1;
        start   = 1'b1;
        t_count = 16'(t);
        @(posedge clk); #1;
        start   = 1'b0;
        t_count = 16'($urandom);
        check("R8", "busy after accept", 64'(busy_a), 64'd1);
        k = 0;
        seen = 0;
        while (!seen && k < t + 20) begin
            @(posedge clk); #1;
            k++;
            if (k == noise_at) begin
                start   = 1'b1;
                t_count = 16'd3;
            end else begin
                start = 1'b0;
            end
            if (done_a) seen = 1;
        end
        start = 1'b0;
        check("R4", "done latency", 64'(k), 64'(t + 2));
        check("R4", "all done together", 64'({done_b, done_c, done_d}), 64'd7);
        check("R8", "busy low at done", 64'(busy_a), 64'd0);
        check(req, "result n=253",        64'(res_a), ref_sq(NA, t));
        check(req, "result n=9",          64'(res_b), ref_sq(NB, t));
        check(req, "result n=4294967291", 64'(res_c), ref_sq(NC, t));
        check(req, "result n=3001",       64'(res_d), ref_sq(ND, t));
        check("R9", "below modulus", 64'(res_c < 32'hFFFF_FFFB), 64'd1);
        ha = 64'(res_a); hb = 64'(res_b); hc = 64'(res_c); hd = 64'(res_d);
        @(posedge clk); #1;
        check("R5", "done one cycle", 64'(done_a), 64'd0);
        check("R6", "result held a", 64'(res_a), ha);
        check("R6", "result held bcd", 64'({res_b, res_c, res_d}) ,
              64'({hb[15:0], hc[31:0], hd[11:0]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp253 [11] = '{2, 4, 16, 3, 9, 81, 236, 36, 31, 202, 71};
        longint unsigned hold_a, hold_c;
        void'($urandom(1234));
        rst = 1'b1;
        start = 1'b0;
        t_count = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10", "busy/done in reset", 64'({busy_a, done_a, busy_c, done_c}), 64'd0);
        check("R10", "result in reset", 64'(res_a) + 64'(res_c), 64'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R10", "after release", 64'({busy_a, done_a}) + 64'(res_d), 64'd0);

        // R3: zero squarings
        run_job(0, 0, "R3");
        check("R3", "t=0 gives 2", 64'(res_a), 64'd2);

        // R2: worked sequence for n = 253
        for (int t = 1; t <= 10; t++) begin
            run_job(t, 0, "R2");
            check("R2", "sequence value", 64'(res_a), 64'(exp253[t]));
        end

        // R7: start and count changes during a run
        run_job(25, 7, "R7");
        run_job(4, 4, "R7");

        // R6: idle interval with toggling inputs but no start
        hold_a = 64'(res_a);
        hold_c = 64'(res_c);
        for (int i = 0; i < 15; i++) begin
            @(posedge clk); #1;
            t_count = 16'($urandom);
            check("R6", "no done while idle", 64'(done_a), 64'd0);
        end
        check("R6", "idle hold a", 64'(res_a), hold_a);
        check("R6", "idle hold c", 64'(res_c), hold_c);

        // R1: random counts, some with injected noise
        for (int j = 0; j < 30; j++) begin
            int t;
            int nz;
            t  = int'($urandom_range(0, 200));
            nz = (t > 0 && ($urandom % 2 == 0)) ? int'($urandom_range(1, t)) : 0;
            run_job(t, nz, "R1");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule